// File: doc/BRIEF.md
# Hybrid Lookahead Carry-Select Adder/Subtractor

This block is a purely combinational wide adder with a subtract option. It takes two operands, an external carry-in and a subtract control, and returns the word-wide result together with the carry out of the top bit. There are no registers, so the outputs follow the inputs within the same evaluation.

Carries are resolved in three levels. Small groups of bits form their internal carries in parallel from per-bit generate (AND) and propagate (XOR) terms. Each group also exports a group generate and a group propagate. Larger blocks are made of several groups, and each block evaluates its groups twice, once assuming an incoming carry of 0 and once assuming 1. A top-level lookahead stage then derives the true carry into every block from the block generate/propagate pairs, and that carry steers a select multiplexer between the two precomputed results.

Subtraction inverts the second operand and forces the lowest carry-in to 1, so the result is the first operand minus the second in two's complement. The carry-out then reads 1 when no borrow occurred.

Top module: `hlcs_adder`

## Requirements
- R1: With `do_sub`=0, `{carry_out, result}` equals the 65-bit sum `op_a + op_b + carry_in`, for every operand pattern.
- R2: With `do_sub`=1, `result` equals `op_a - op_b` modulo 2^64, and `carry_out` is 1 exactly when `op_a >= op_b` (unsigned).
- R3: A carry entering a 4-bit group crosses it whenever every bit in the group propagates. For example, all-ones plus 0 with `carry_in`=1 gives zero with `carry_out`=1.
- R4: A carry produced below a 16-bit block boundary reaches the block above it. For example, `(2^(16k))-1 + 1` gives `2^(16k)` for k = 1, 2 and 3.
- R5: Zero minus one gives all ones with `carry_out`=0.
- R6: With `do_sub`=1, the value of `carry_in` has no effect on `result` or `carry_out`.
- R7: The outputs depend only on the present inputs. They are valid 1 ns after an input change, with no clock involved.
- R8: The carry out of bit 63 is presented on `carry_out`. For example, 2^63 + 2^63 gives `result`=0 and `carry_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand (minuend when subtracting) |
| op_b | input | 64 | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Low carry-in, used in add mode only |
| do_sub | input | 1 | 1 selects op_a minus op_b |
| result | output | 64 | Sum or difference |
| carry_out | output | 1 | Carry out of the most significant bit (1 = no borrow when subtracting) |

## Verification
The bench builds the adder with its defaults: 64 bits, 16-bit select blocks and 4-bit lookahead groups. With these values every group boundary, every block boundary and the top-level lookahead across four blocks are all exercised. The random operands are biased toward long runs of propagating bits, so carries that start at bit 0 regularly travel across several groups and blocks. The directed cases place a carry exactly at each 4-bit and 16-bit edge and at the most significant bit.

// File: rtl/hlcs_pkg.sv
package hlcs_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Combine a higher pair with a lower pair into one covering both.
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Carry into position n of a span, written as a flat sum of products
  // over generates and the span carry-in (parallel, not a chain).
  function automatic logic la_carry(input logic [31:0] g, input logic [31:0] p,
                                    input int n, input logic cin);
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < 32; j++) begin
      if (j < n) begin
        prod = g[j];
        for (int k = 0; k < 32; k++) begin
          if (k > j && k < n) prod = prod & p[k];
        end
        acc = acc | prod;
      end
    end
    prod = cin;
    for (int k = 0; k < 32; k++) begin
      if (k < n) prod = prod & p[k];
    end
    return acc | prod;
  endfunction

endpackage

// File: rtl/cla_group.sv
module cla_group
  import hlcs_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          grp_g,
  output logic          grp_p,
  output logic          cout
);

  logic [GW-1:0] bit_g;
  logic [GW-1:0] bit_p;
  logic [GW:0]   c;

  assign bit_g = a & b;
  assign bit_p = a ^ b;

  always_comb begin
    for (int i = 0; i <= GW; i++) begin
      c[i] = la_carry(32'(bit_g), 32'(bit_p), i, cin);
    end
  end

  assign sum  = bit_p ^ c[GW-1:0];
  assign cout = c[GW];

  always_comb begin
    gp_t acc;
    acc = '{g: 1'b0, p: 1'b1};
    for (int i = 0; i < GW; i++) begin
      acc = gp_merge('{g: bit_g[i], p: bit_p[i]}, acc);
    end
    grp_g = acc.g;
    grp_p = acc.p;
  end

  // R3: folded group pair and flat carry expansion agree
  always_comb begin
    p_grp_cout_r3: assert (cout == (grp_g | (grp_p & cin)))
      else $error("group carry-out disagrees with group generate/propagate");
    p_grp_excl_r3: assert (!(grp_g && grp_p))
      else $error("group both generates and propagates");
  end

endmodule

// File: rtl/csel_block.sv
module csel_block
  import hlcs_pkg::*;
#(
  parameter int BW = 16,
  parameter int GW = 4
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [BW-1:0] sum0,
  output logic [BW-1:0] sum1,
  output logic          cout0,
  output logic          cout1,
  output logic          blk_g,
  output logic          blk_p
);

  localparam int NG = BW / GW;

  for (genvar v = 0; v < 2; v++) begin : g_var
    logic [NG-1:0] gg;
    logic [NG-1:0] gp;
    logic [NG-1:0] gco;
    logic [NG:0]   cc;
    logic [BW-1:0] ss;

    always_comb begin
      for (int j = 0; j <= NG; j++) begin
        cc[j] = la_carry(32'(gg), 32'(gp), j, 1'(v));
      end
    end

    for (genvar j = 0; j < NG; j++) begin : g_grp
      cla_group #(.GW(GW)) i_grp (
        .a     (a[j*GW +: GW]),
        .b     (b[j*GW +: GW]),
        .cin   (cc[j]),
        .sum   (ss[j*GW +: GW]),
        .grp_g (gg[j]),
        .grp_p (gp[j]),
        .cout  (gco[j])
      );

      // R3: carry leaving a group equals the lookahead carry into the next
      always_comb begin
        p_grp_link_r3: assert (gco[j] == cc[j+1])
          else $error("group carry-out differs from block lookahead carry");
      end
    end
  end

  assign sum0  = g_var[0].ss;
  assign sum1  = g_var[1].ss;
  assign cout0 = g_var[0].cc[NG];
  assign cout1 = g_var[1].cc[NG];

  always_comb begin
    gp_t acc;
    acc = '{g: 1'b0, p: 1'b1};
    for (int j = 0; j < NG; j++) begin
      acc = gp_merge('{g: g_var[0].gg[j], p: g_var[0].gp[j]}, acc);
    end
    blk_g = acc.g;
    blk_p = acc.p;
  end

  // R4: carry-in 1 never yields less carry than carry-in 0; pair matches both copies
  always_comb begin
    p_sel_monotone_r4: assert (!cout0 || cout1)
      else $error("carry-in 0 copy carries while carry-in 1 copy does not");
    p_blk_pair_r4: assert ((cout0 == blk_g) && (cout1 == (blk_g | blk_p)))
      else $error("block generate/propagate disagree with precomputed carries");
  end

endmodule

// File: rtl/hlcs_adder.sv
module hlcs_adder
  import hlcs_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int BLOCK = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             do_sub,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  localparam int NBLK = WIDTH / BLOCK;

  logic [WIDTH-1:0] b_eff;
  logic             c0;
  logic [WIDTH-1:0] s0;
  logic [WIDTH-1:0] s1;
  logic [NBLK-1:0]  co0;
  logic [NBLK-1:0]  co1;
  logic [NBLK-1:0]  bg;
  logic [NBLK-1:0]  bp;
  logic [NBLK:0]    blk_cin;

  assign b_eff = do_sub ? ~op_b : op_b;
  assign c0    = do_sub | carry_in;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    csel_block #(.BW(BLOCK), .GW(GROUP)) i_blk (
      .a     (op_a[k*BLOCK +: BLOCK]),
      .b     (b_eff[k*BLOCK +: BLOCK]),
      .sum0  (s0[k*BLOCK +: BLOCK]),
      .sum1  (s1[k*BLOCK +: BLOCK]),
      .cout0 (co0[k]),
      .cout1 (co1[k]),
      .blk_g (bg[k]),
      .blk_p (bp[k])
    );

    assign result[k*BLOCK +: BLOCK] = blk_cin[k] ? s1[k*BLOCK +: BLOCK]
                                                 : s0[k*BLOCK +: BLOCK];

    // R4: selected block carry-out matches the top lookahead carry above it
    always_comb begin
      p_blk_chain_r4: assert ((blk_cin[k] ? co1[k] : co0[k]) == blk_cin[k+1])
        else $error("selected block carry disagrees with top-level lookahead");
    end
  end

  always_comb begin
    for (int k = 0; k <= NBLK; k++) begin
      blk_cin[k] = la_carry(32'(bg), 32'(bp), k, c0);
    end
  end

  assign carry_out = blk_cin[NBLK];

  logic [WIDTH:0] ref_total;
  logic [WIDTH-1:0] ref_diff;
  assign ref_total = {1'b0, op_a} + {1'b0, b_eff} + (WIDTH+1)'(c0);
  assign ref_diff  = op_a - op_b;

  always_comb begin
    p_total_r1: assert ({carry_out, result} == ref_total)
      else $error("result differs from plain addition");
    if (do_sub) begin
      p_diff_r2: assert (result == ref_diff)
        else $error("difference wrong in subtract mode");
    end
  end

endmodule

// File: tb/test_hlcs_adder.sv
`timescale 1ns/1ps
module test_hlcs_adder;

  logic        clk = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic        do_sub = 1'b0;
  logic [63:0] result;
  logic        carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  hlcs_adder i_hlcs_adder (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .do_sub    (do_sub),
    .result    (result),
    .carry_out (carry_out)
  );

  // Expected value restated from the requirements
  function automatic logic [64:0] expect_val(input logic [63:0] a, input logic [63:0] b,
                                             input logic cin, input logic sub);
    logic [64:0] r;
    if (sub) begin
      r[63:0] = a - b;
      r[64]   = (a >= b);
    end else begin
      r = {1'b0, a} + {1'b0, b} + {64'd0, cin};
    end
    return r;
  endfunction

  task automatic apply(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic cin, input logic sub);
    logic [64:0] e;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = cin; do_sub = sub;
    #1;  // R7: valid 1 ns after the change, no clock edge needed
    e = expect_val(a, b, cin, sub);
    n_checks++;
    if ({carry_out, result} !== e) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%b sub=%b got %b_%h exp %b_%h",
               tag, a, b, cin, sub, carry_out, result, e[64], e[63:0]);
    end
  endtask

  task automatic apply_fixed(input string tag, input logic [63:0] a, input logic [63:0] b,
                             input logic cin, input logic sub,
                             input logic [63:0] exp_r, input logic exp_c);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = cin; do_sub = sub;
    #1;
    n_checks++;
    if (result !== exp_r || carry_out !== exp_c) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%b sub=%b got %b_%h exp %b_%h",
               tag, a, b, cin, sub, carry_out, result, exp_c, exp_r);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb, x0, x1;
    logic [64:0] e_sub0, e_sub1;
    void'($urandom(32'd20240611));

    // R1: idle inputs
    apply_fixed("R1 zero", 64'd0, 64'd0, 1'b0, 1'b0, 64'd0, 1'b0);
    apply_fixed("R1 small", 64'd11, 64'd7, 1'b0, 1'b0, 64'd18, 1'b0);

    // R3: full propagation across every 4-bit group
    apply_fixed("R3 ones+cin", {64{1'b1}}, 64'd0, 1'b1, 1'b0, 64'd0, 1'b1);
    apply_fixed("R3 ones+1", {64{1'b1}}, 64'd1, 1'b0, 1'b0, 64'd0, 1'b1);
    for (int g = 1; g < 16; g++) begin
      apply_fixed("R3 group edge", (64'd1 << (4*g)) - 64'd1, 64'd1, 1'b0, 1'b0,
                  64'd1 << (4*g), 1'b0);
    end

    // R4: carries crossing each 16-bit block boundary
    for (int k = 1; k < 4; k++) begin
      apply_fixed("R4 block edge", (64'd1 << (16*k)) - 64'd1, 64'd1, 1'b0, 1'b0,
                  64'd1 << (16*k), 1'b0);
      apply_fixed("R4 block edge cin", (64'd1 << (16*k)) - 64'd1, 64'd0, 1'b1, 1'b0,
                  64'd1 << (16*k), 1'b0);
    end

    // R5: zero minus one
    apply_fixed("R5 0-1", 64'd0, 64'd1, 1'b0, 1'b1, {64{1'b1}}, 1'b0);

    // R2: subtract corners
    apply_fixed("R2 a-a", 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 1'b0, 1'b1,
                64'd0, 1'b1);
    apply_fixed("R2 18-7", 64'd18, 64'd7, 1'b0, 1'b1, 64'd11, 1'b1);

    // R8: carry out of the top bit
    apply_fixed("R8 msb", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0,
                64'd0, 1'b1);

    // R6: carry_in ignored in subtract mode
    for (int i = 0; i < 40; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      apply("R6 sub cin0", ra, rb, 1'b0, 1'b1);
      x0 = result; e_sub0 = {carry_out, result};
      apply("R6 sub cin1", ra, rb, 1'b1, 1'b1);
      x1 = result; e_sub1 = {carry_out, result};
      n_checks++;
      if (e_sub0 !== e_sub1 || x0 !== x1) begin
        n_fail++;
        $display("FAIL R6: cin changed subtract output got %h exp %h", e_sub1, e_sub0);
      end
    end

    // R1 / R2 / R7: random operands, biased toward long propagate runs
    for (int i = 0; i < 3000; i++) begin
      ra = {$urandom, $urandom};
      case ($urandom % 4)
        0: rb = {$urandom, $urandom};
        1: rb = ~ra ^ (64'd1 << ($urandom % 64));
        2: rb = ~ra;
        default: rb = {$urandom, $urandom} & (64'hFFFF << (16 * ($urandom % 4)));
      endcase
      apply((i % 2 == 0) ? "R1 random add" : "R2 random sub", ra, rb,
            1'($urandom), 1'(i % 2));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule